// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Pattern Flags

This block sits behind a demodulator that already delivers a binary bitstream. It hunts for start bits on that line with a 16x oversampling enable, confirms each start bit at mid-bit, and takes one sample from the middle of every following bit to build a character and its even parity. A finished character first goes into a one-entry hold buffer. On the next cycle it moves into the data register that the host reads, and the data-ready flag is set at the same moment.

Alongside the framer, three watchers look at the raw line, taking one sample per bit time on a free-running divider. The first catches the alternating pattern 1,0,1,0. The second catches a run of zeros of programmable length, and the third catches a run of ones of that same length. Their results, together with data-ready, parity, framing-error and overrun, are gathered into a status word. The host clears data-ready with a data-read strobe and clears the sticky flags with a status-read strobe.

Top module: `ser_rx_framer`

## Requirements
- R1: A frame is idle-high line, one start bit (0), DATA_W data bits sent least significant bit first, one parity bit when PARITY_EN is set, and one stop bit (1). Each bit lasts OVS pulses of `ovs_en`. The received character appears on `data_o`, and this holds whether `ovs_en` is high every cycle or only every other cycle.
- R2: A low level that is no longer low at the middle of the start bit (OVS/2 enables after the falling edge) is discarded. It produces no character and leaves status bit 0 clear.
- R3: A finished character passes through a hold buffer into the data register. Status bit 0 (data ready) is set in the cycle the register loads. `data_o` does not change in any other cycle.
- R4: Status bit 1 (parity good) is 1 when the data bits and the parity bit together hold an even number of ones, and 0 otherwise. It is rewritten with every character and is stable between characters.
- R5: A one-cycle pulse on `rd_data` clears status bit 0. If the pulse falls in the same cycle as a register load, the load wins and bit 0 stays set.
- R6: A stop bit sampled low sets sticky status bit 2 (framing error) while still delivering the character. After that the receiver ignores the line until it has returned high, so a line held low does not start another frame.
- R7: A character loaded while bit 0 is set and no `rd_data` is present in that cycle sets sticky status bit 3 (overrun). `data_o` then takes the newer character.
- R8: A pulse on `rd_stat` clears status bits 2, 3, 7, 8 and 9 and leaves bits 0 and 1 unchanged.
- R9: The raw line is sampled once every OVS enables, whether or not a frame is in progress. Status bit 8 is set once `run_len` consecutive samples are 0. A run of `run_len`-1 zeros does not set it.
- R10: Status bit 7 is set once `run_len` consecutive line samples are 1. A run of `run_len`-1 ones does not set it.
- R11: Status bit 9 is set when four consecutive line samples are 1,0,1,0, oldest first. No other window of four samples sets it.
- R12: After reset `data_o` and every status bit are 0. Status bits 4 to 6 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovs_en | input | 1 | Oversampling enable, OVS pulses per bit |
| rx_line | input | 1 | Demodulated serial bitstream, idle high |
| run_len | input | RUN_W | Run length for the zero and one run flags |
| rd_data | input | 1 | Host data-register read strobe, clears data ready |
| rd_stat | input | 1 | Host status read strobe, clears sticky flags |
| data_o | output | DATA_W | Received data register |
| status_o | output | 10 | Status word: 0 ready, 1 parity good, 2 framing, 3 overrun, 7 ones run, 8 zeros run, 9 alternating |

## Verification
Two events can land on the same clock edge: the host's data-read strobe and the transfer of a newly finished character from the hold buffer into the data register. The bench provokes this by keeping `rd_data` high for the whole frame. It then watches the output on falling edges: data-ready must be seen high with the new character while the strobe is still asserted, which shows that the load took priority over the clear. The overrun test is the other side of the same case: a load with data-ready set and no read in that cycle must raise the overrun flag.

// File: rtl/rx_framer_pkg.sv
package rx_framer_pkg;
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_PAR,
      FR_STOP,
      FR_WAIT_HI
   } fr_state_t;

   localparam int STAT_W   = 10;
   localparam int SB_RDY   = 0;
   localparam int SB_PAROK = 1;
   localparam int SB_FRM   = 2;
   localparam int SB_OVR   = 3;
   localparam int SB_ONES  = 7;
   localparam int SB_ZEROS = 8;
   localparam int SB_ALT   = 9;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_framer_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OVS       = 16,
   parameter int PARITY_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ovs_en,
   input  logic              rx_s,
   output logic              done_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              par_ok_o,
   output logic              frm_err_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(DATA_W - 1);

   fr_state_t          st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [DATA_W-1:0]  sh_q;
   logic               par_q;
   logic               after_data;
   logic               par_res;

   generate
      if (PARITY_EN != 0) begin : g_par
         assign after_data = 1'b1;
         assign par_res    = ~par_q;
      end else begin : g_nopar
         assign after_data = 1'b0;
         assign par_res    = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FR_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         sh_q      <= '0;
         par_q     <= 1'b0;
         done_o    <= 1'b0;
         byte_o    <= '0;
         par_ok_o  <= 1'b0;
         frm_err_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            FR_IDLE: begin
               if (ovs_en && !rx_s) begin
                  st_q  <= FR_START;
                  cnt_q <= '0;
               end
            end
            FR_START: begin
               if (ovs_en) begin
                  if (cnt_q == HALF_M1) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     par_q <= 1'b0;
                     st_q  <= rx_s ? FR_IDLE : FR_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FR_DATA: begin
               if (ovs_en) begin
                  if (cnt_q == FULL_M1) begin
                     cnt_q <= '0;
                     sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                     par_q <= par_q ^ rx_s;
                     if (idx_q == LAST_IX) st_q <= after_data ? FR_PAR : FR_STOP;
                     else                  idx_q <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FR_PAR: begin
               if (ovs_en) begin
                  if (cnt_q == FULL_M1) begin
                     cnt_q <= '0;
                     par_q <= par_q ^ rx_s;
                     st_q  <= FR_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FR_STOP: begin
               if (ovs_en) begin
                  if (cnt_q == FULL_M1) begin
                     cnt_q     <= '0;
                     done_o    <= 1'b1;
                     byte_o    <= sh_q;
                     par_ok_o  <= par_res;
                     frm_err_o <= ~rx_s;
                     st_q      <= rx_s ? FR_IDLE : FR_WAIT_HI;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FR_WAIT_HI: begin
               if (rx_s) st_q <= FR_IDLE;
            end
            default: st_q <= FR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rx_pattern_det.sv
module rx_pattern_det #(
   parameter int OVS   = 16,
   parameter int RUN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovs_en,
   input  logic             rx_s,
   input  logic [RUN_W-1:0] run_len,
   output logic             tick_o,
   output logic             alt_hit_o,
   output logic             zero_hit_o,
   output logic             one_hit_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] DIV_M1  = CNT_W'(OVS - 1);
   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

   logic [CNT_W-1:0] div_q;
   logic [2:0]       hist_q;
   logic [1:0]       run_hit;

   assign tick_o    = ovs_en && (div_q == DIV_M1);
   assign alt_hit_o = tick_o && ({hist_q, rx_s} == 4'b1010);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         hist_q <= '0;
      end else if (ovs_en) begin
         div_q <= (div_q == DIV_M1) ? '0 : div_q + 1'b1;
         if (tick_o) hist_q <= {hist_q[1:0], rx_s};
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_run
      logic [RUN_W-1:0] len_q;
      logic [RUN_W-1:0] len_nxt;
      logic             match;

      assign match   = (rx_s == (p == 1));
      assign len_nxt = (len_q == RUN_MAX) ? len_q : len_q + 1'b1;
      assign run_hit[p] = tick_o && match && (len_nxt >= run_len);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      len_q <= '0;
         else if (tick_o) len_q <= match ? len_nxt : '0;
      end
   end

   assign zero_hit_o = run_hit[0];
   assign one_hit_o  = run_hit[1];
endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs
   import rx_framer_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              par_ok_i,
   input  logic              frm_err_i,
   input  logic              rd_data,
   input  logic              rd_stat,
   input  logic              alt_hit,
   input  logic              zero_hit,
   input  logic              one_hit,
   output logic              buf_vld_o,
   output logic [DATA_W-1:0] data_o,
   output logic [STAT_W-1:0] status_o
);
   logic [DATA_W-1:0] buf_q;
   logic              buf_par_q, buf_frm_q;
   logic              rdy_q, par_q, frm_q, ovr_q, alt_q, zer_q, one_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_vld_o <= 1'b0;
         buf_q     <= '0;
         buf_par_q <= 1'b0;
         buf_frm_q <= 1'b0;
         data_o    <= '0;
         rdy_q     <= 1'b0;
         par_q     <= 1'b0;
         frm_q     <= 1'b0;
         ovr_q     <= 1'b0;
         alt_q     <= 1'b0;
         zer_q     <= 1'b0;
         one_q     <= 1'b0;
      end else begin
         buf_vld_o <= done_i;
         if (done_i) begin
            buf_q     <= byte_i;
            buf_par_q <= par_ok_i;
            buf_frm_q <= frm_err_i;
         end
         if (buf_vld_o) begin
            data_o <= buf_q;
            par_q  <= buf_par_q;
            rdy_q  <= 1'b1;
         end else if (rd_data) begin
            rdy_q  <= 1'b0;
         end
         frm_q <= (buf_vld_o && buf_frm_q) || (frm_q && !rd_stat);
         ovr_q <= (buf_vld_o && rdy_q && !rd_data) || (ovr_q && !rd_stat);
         alt_q <= alt_hit  || (alt_q && !rd_stat);
         zer_q <= zero_hit || (zer_q && !rd_stat);
         one_q <= one_hit  || (one_q && !rd_stat);
      end
   end

   always_comb begin
      status_o           = '0;
      status_o[SB_RDY]   = rdy_q;
      status_o[SB_PAROK] = par_q;
      status_o[SB_FRM]   = frm_q;
      status_o[SB_OVR]   = ovr_q;
      status_o[SB_ONES]  = one_q;
      status_o[SB_ZEROS] = zer_q;
      status_o[SB_ALT]   = alt_q;
   end
endmodule

// File: rtl/ser_rx_framer.sv
module ser_rx_framer
   import rx_framer_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OVS       = 16,
   parameter int PARITY_EN = 1,
   parameter int RUN_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ovs_en,
   input  logic              rx_line,
   input  logic [RUN_W-1:0]  run_len,
   input  logic              rd_data,
   input  logic              rd_stat,
   output logic [DATA_W-1:0] data_o,
   output logic [STAT_W-1:0] status_o
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("DATA_W must be at least 2");
   end
   if (RUN_W < 2) begin : g_bad_rw
      $error("RUN_W must be at least 2");
   end

   logic [1:0]        sync_q;
   logic              rx_s;
   logic              done_w, par_ok_w, frm_err_w, buf_vld;
   logic [DATA_W-1:0] byte_w;
   logic              det_tick, alt_hit, zero_hit, one_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], rx_line};
   end
   assign rx_s = sync_q[1];

   rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS), .PARITY_EN(PARITY_EN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ovs_en(ovs_en), .rx_s(rx_s),
      .done_o(done_w), .byte_o(byte_w), .par_ok_o(par_ok_w), .frm_err_o(frm_err_w)
   );

   rx_pattern_det #(.OVS(OVS), .RUN_W(RUN_W)) u_det (
      .clk(clk), .rst_n(rst_n), .ovs_en(ovs_en), .rx_s(rx_s), .run_len(run_len),
      .tick_o(det_tick), .alt_hit_o(alt_hit), .zero_hit_o(zero_hit), .one_hit_o(one_hit)
   );

   rx_hold_regs #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .done_i(done_w), .byte_i(byte_w),
      .par_ok_i(par_ok_w), .frm_err_i(frm_err_w), .rd_data(rd_data), .rd_stat(rd_stat),
      .alt_hit(alt_hit), .zero_hit(zero_hit), .one_hit(one_hit),
      .buf_vld_o(buf_vld), .data_o(data_o), .status_o(status_o)
   );
endmodule

// File: rtl/rx_framer_chk.sv
module rx_framer_chk
   import rx_framer_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_data,
   input logic              rd_stat,
   input logic              done_w,
   input logic              buf_vld,
   input logic              det_tick,
   input logic              alt_hit,
   input logic              zero_hit,
   input logic              one_hit,
   input logic [DATA_W-1:0] data_o,
   input logic [STAT_W-1:0] status_o
);
   assert_buf_follows_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_w |=> buf_vld);

   assert_ready_from_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[SB_RDY]) |-> $past(buf_vld));

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_vld |=> $stable(data_o));

   assert_parity_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_vld |=> $stable(status_o[SB_PAROK]));

   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !buf_vld) |=> !status_o[SB_RDY]);

   assert_load_beats_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_vld |=> status_o[SB_RDY]);

   assert_frm_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[SB_FRM]) |-> $past(buf_vld));

   assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_vld && status_o[SB_RDY] && !rd_data) |=> status_o[SB_OVR]);

   assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !buf_vld) |=> !status_o[SB_OVR] && !status_o[SB_FRM]);

   assert_run_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_hit || one_hit || alt_hit) |-> det_tick);

   assert_run_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(zero_hit && one_hit));

   assert_spare_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6:4] == 3'b000);
endmodule

bind ser_rx_framer rx_framer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_stat(rd_stat),
   .done_w(done_w), .buf_vld(buf_vld), .det_tick(det_tick),
   .alt_hit(alt_hit), .zero_hit(zero_hit), .one_hit(one_hit),
   .data_o(data_o), .status_o(status_o)
);

// File: tb/tb_ser_rx_framer.sv
module tb_ser_rx_framer;
   localparam int OVS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ovs_en = 1'b1;
   logic       rx_line = 1'b1;
   logic [4:0] run_len = 5'd10;
   logic       rd_data = 1'b0;
   logic       rd_stat = 1'b0;
   logic [7:0] data_o;
   logic [9:0] status_o;
   logic       half_rate = 1'b0;
   logic       finished = 1'b0;
   int         checks = 0;
   int         errors = 0;

   ser_rx_framer dut (
      .clk(clk), .rst_n(rst_n), .ovs_en(ovs_en), .rx_line(rx_line),
      .run_len(run_len), .rd_data(rd_data), .rd_stat(rd_stat),
      .data_o(data_o), .status_o(status_o)
   );

   always #2 clk = ~clk;

   always @(negedge clk) ovs_en <= half_rate ? ~ovs_en : 1'b1;

   function automatic logic even_ok(input logic [7:0] b, input logic p);
      return ~(^{b, p});
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      rx_line = b;
      repeat (half_rate ? 2*OVS : OVS) @(negedge clk);
   endtask

   task automatic send_bit_clr(input logic b);
      rx_line = b;
      rd_stat = 1'b1;
      @(negedge clk);
      rd_stat = 1'b0;
      repeat (OVS-1) @(negedge clk);
   endtask

   task automatic send_body(input logic [7:0] b, input logic bad_par);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
      send_bit((^b) ^ bad_par);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic bad_par);
      send_body(b, bad_par);
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b1);
   endtask

   task automatic pulse_rd();
      rd_data = 1'b1;
      @(negedge clk);
      rd_data = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_stat();
      rd_stat = 1'b1;
      @(negedge clk);
      rd_stat = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      logic [7:0] b;
      logic       bad;
      logic       seen;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      chk("R12 reset data_o", data_o, 0);
      chk("R12 reset status", status_o, 0);
      rst_n = 1'b1;
      repeat (3) send_bit(1'b1);

      // directed good frame
      send_frame(8'hA5, 1'b0);
      chk("R1 data A5", data_o, 8'hA5);
      chk("R3 ready set", status_o[0], 1);
      chk("R4 parity good", status_o[1], 1);
      chk("R6 no framing err", status_o[2], 0);
      chk("R12 spare bits", status_o[6:4], 0);
      pulse_rd();
      chk("R5 read clears ready", status_o[0], 0);

      // random frames, some with broken parity
      for (int n = 0; n < 20; n++) begin
         b   = 8'($urandom);
         bad = (($urandom % 4) == 0);
         send_frame(b, bad);
         chk("R1 random data", data_o, b);
         chk("R4 random parity", status_o[1], even_ok(b, (^b) ^ bad));
         chk("R3 random ready", status_o[0], 1);
         pulse_rd();
         chk("R5 random read", status_o[0], 0);
      end

      // parity failure on all-zero byte
      send_frame(8'h00, 1'b1);
      chk("R4 bad parity flag", status_o[1], 0);
      pulse_rd();

      // glitch shorter than half a bit
      rx_line = 1'b0;
      repeat (5) @(negedge clk);
      rx_line = 1'b1;
      repeat (3) send_bit(1'b1);
      chk("R2 glitch ignored", status_o[0], 0);
      send_frame(8'h3C, 1'b0);
      chk("R2 frame after glitch", data_o, 8'h3C);
      pulse_rd();

      // enable every other cycle
      half_rate = 1'b1;
      send_frame(8'h96, 1'b0);
      half_rate = 1'b0;
      send_bit(1'b1);
      chk("R1 half-rate data", data_o, 8'h96);
      chk("R1 half-rate parity", status_o[1], 1);
      pulse_rd();

      // data read collides with register load
      rd_data = 1'b1;
      send_body(8'h4E, 1'b0);
      rx_line = 1'b1;
      seen = 1'b0;
      for (int t = 0; t < 48 && !seen; t++) begin
         @(negedge clk);
         if (status_o[0]) seen = 1'b1;
      end
      rd_data = 1'b0;
      chk("R5 load wins over read", seen, 1);
      chk("R5 collided data", data_o, 8'h4E);
      repeat (2) send_bit(1'b1);
      chk("R5 ready kept after strobe", status_o[0], 1);
      pulse_rd();

      // overrun
      pulse_stat();
      send_frame(8'h11, 1'b0);
      send_frame(8'h22, 1'b0);
      chk("R7 overrun flag", status_o[3], 1);
      chk("R7 newest data kept", data_o, 8'h22);
      pulse_stat();
      chk("R8 overrun cleared", status_o[3], 0);
      chk("R8 ready untouched", status_o[0], 1);
      pulse_rd();

      // framing error with line held low afterwards
      send_body(8'h5A, 1'b0);
      repeat (3) send_bit(1'b0);
      repeat (12) send_bit(1'b1);
      chk("R6 framing flag", status_o[2], 1);
      chk("R6 data delivered", data_o, 8'h5A);
      chk("R6 no restart while low", status_o[3], 0);
      pulse_stat();
      chk("R8 framing cleared", status_o[2], 0);
      pulse_rd();

      // zero runs
      pulse_stat();
      repeat (9) send_bit(1'b0);
      repeat (3) send_bit(1'b1);
      chk("R9 nine zeros no flag", status_o[8], 0);
      repeat (10) send_bit(1'b0);
      repeat (3) send_bit(1'b1);
      chk("R9 ten zeros flag", status_o[8], 1);

      // one runs
      send_bit(1'b0);
      send_bit_clr(1'b0);
      repeat (9) send_bit(1'b1);
      repeat (3) send_bit(1'b0);
      chk("R10 nine ones no flag", status_o[7], 0);
      chk("R9 short zero run no flag", status_o[8], 0);
      repeat (10) send_bit(1'b1);
      repeat (3) send_bit(1'b0);
      chk("R10 ten ones flag", status_o[7], 1);

      // alternating pattern
      send_bit_clr(1'b0);
      foreach (b[i]) send_bit(8'b1011_0011 >> (7 - i));
      repeat (2) send_bit(1'b1);
      chk("R11 no 1010 window", status_o[9], 0);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      repeat (2) send_bit(1'b1);
      chk("R11 1010 flag", status_o[9], 1);
      pulse_stat();
      repeat (2) send_bit(1'b1);
      chk("R8 alt cleared", status_o[9], 0);

      finished = 1'b1;
      finish_run();
   end
endmodule